// File: doc/BRIEF.md
# Inter-Task Register Reservation Unit

This unit keeps register dependences correct between tasks that run speculatively on a ring of processing elements. When a task is placed on the ring, it brings a create mask: one bit per architectural register that the task might write. Each bit stays pending until one of three things happens. The task forwards a value for that register. The task releases the register because it will not write it after all. The task reaches its stop point, which releases every bit it still holds.

A younger task must not read a register while any live older task still holds a pending bit for it. The unit answers a single read-readiness query each cycle. For the queried slot it forms the OR of the pending masks of all live older tasks and checks the queried register against that combined mask. A task's own create mask never blocks its own reads.

Tasks are allocated at the tail of the ring and retire in ring order from the head. A task retires only after it has reached its stop point. A squash removes a chosen task and every task younger than it, together with all the reservations those tasks held. The register values themselves are stored elsewhere.

Top module: `rsv_unit`

## Requirements
- R1: After a synchronous active-low reset, no slot is live, no slot is done, the head and the allocation slot are both 0, the ring is not full, and every query reports ready.
- R2: An allocation request loads its create mask as the pending set of the slot at `alloc_slot`, which is the head plus the live count, modulo the task count. That slot becomes live with its done flag clear. When all slots are live, `ring_full` is 1 and an allocation request is ignored.
- R3: `qry_ready` is 0 exactly when some live slot strictly older than `qry_slot` in ring order, counted from the head, has the pending bit for `qry_reg` set. A dead `qry_slot` is treated as younger than every live slot.
- R4: A forward event on a live slot clears that slot's pending bit for `fwd_reg` and no other bit.
- R5: A release event on a live slot clears every pending bit of that slot that is set in `rel_mask`.
- R6: A stop event on a live slot clears all of that slot's pending bits and sets its done flag.
- R7: A commit request retires the head slot and advances the head by one only when at least one slot is live and the head slot's done flag is set. Otherwise the request is ignored.
- R8: A squash of a live slot removes that slot and every younger live slot, clears their pending bits and done flags, and sets the live count to the squashed slot's age. In the same cycle it suppresses any allocation or commit request.
- R9: Forward, release, stop and squash events that name a dead slot have no effect.
- R10: A slot's own pending bits never make its own query report not ready, so the head slot is always ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a task at the tail |
| alloc_create | input | 32 | Create mask of the new task |
| commit_valid | input | 1 | Retire the head task if it is done |
| squash_valid | input | 1 | Squash a task and all younger tasks |
| squash_slot | input | 2 | Slot to squash from |
| fwd_valid | input | 1 | Forward event (instruction with forward bit) |
| fwd_slot | input | 2 | Slot that forwards |
| fwd_reg | input | 5 | Register forwarded |
| rel_valid | input | 1 | Release event |
| rel_slot | input | 2 | Slot that releases |
| rel_mask | input | 32 | Registers released |
| stop_valid | input | 1 | Stop event (end of task) |
| stop_slot | input | 2 | Slot that stops |
| qry_slot | input | 2 | Slot whose read is queried |
| qry_reg | input | 5 | Register read |
| qry_ready | output | 1 | 1 when the read may proceed |
| alloc_slot | output | 2 | Slot the next allocation fills |
| head_slot | output | 2 | Oldest live slot |
| live_mask | output | 4 | Live flag per slot |
| done_mask | output | 4 | Done flag per slot |
| ring_full | output | 1 | All slots live |

## Verification
The embedded assertions check on every cycle that several invariants hold. A dead slot holds no pending bits and no done flag. An allocation loads exactly its create mask. A forward or stop event leaves the named bits clear on the next cycle. A commit or squash moves the head or the live count as the rules require. The head slot always reads as ready. Only the bench's scenarios can show a number of other behaviours. These include the readiness of younger slots across overlapping create masks, the partial clearing done by a release mask, and the removal of a squashed task's reservations as seen by a slot allocated later. They also include an allocation that is ignored while the ring is full and events aimed at dead slots. The bench runs both directed cases and a seeded random stream against its own ring model.

// File: rtl/rsv_pkg.sv
// Package: default sizes shared by the reservation unit and its parts.
// Assumes the task count is a power of two and at least 2.
package rsv_pkg;
    parameter int DEF_NUM_REGS  = 32;
    parameter int DEF_NUM_TASKS = 4;
endpackage

// File: rtl/rsv_ring_ctrl.sv
// Ring controller: keeps the head pointer and the live count and derives per-slot
// liveness and age. It decides which allocate, commit and squash requests take
// effect. Assumes NT is a power of two, so slot arithmetic wraps on its own.
module rsv_ring_ctrl #(
    parameter int NT = rsv_pkg::DEF_NUM_TASKS,
    localparam int SW = $clog2(NT),
    localparam int CW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic          commit_valid,
    input  logic          squash_valid,
    input  logic [SW-1:0] squash_slot,
    input  logic [NT-1:0] done_vec,
    output logic [SW-1:0] head,
    output logic [SW-1:0] tail,
    output logic [NT-1:0] live,
    output logic [NT-1:0] kill_mask,
    output logic [NT-1:0] load_mask,
    output logic          full
);
    logic [CW-1:0] count;
    logic [SW-1:0] age [NT];
    logic [SW-1:0] sq_age;
    logic          sq_fire;
    logic          commit_fire;
    logic          alloc_fire;

    // Age of the squash target and whether the squash takes effect.
    always_comb begin
        sq_age  = squash_slot - head;
        sq_fire = squash_valid && ({1'b0, sq_age} < count);
    end

    // Decide commit and allocation; a squash suppresses both.
    always_comb begin
        commit_fire = !sq_fire && commit_valid && (count != '0) && done_vec[head];
        alloc_fire  = !sq_fire && alloc_valid && (count != CW'(NT));
        tail        = head + count[SW-1:0];
        full        = (count == CW'(NT));
    end

    for (genvar gi = 0; gi < NT; gi++) begin : g_slot
        localparam logic [SW-1:0] IDX = SW'(gi);
        // Per-slot age, liveness, and the clear and load strobes.
        always_comb begin
            age[gi]       = IDX - head;
            live[gi]      = ({1'b0, age[gi]} < count);
            kill_mask[gi] = (sq_fire && live[gi] && (age[gi] >= sq_age))
                          || (commit_fire && (IDX == head));
            load_mask[gi] = alloc_fire && (IDX == tail);
        end
    end

    // Update the head pointer and the live count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
        end else if (sq_fire) begin
            count <= {1'b0, sq_age};
        end else begin
            head  <= head + SW'(commit_fire);
            count <= count - CW'(commit_fire) + CW'(alloc_fire);
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(NT)); // R2
    AST_COMMIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !squash_valid && (count != '0) && done_vec[head])
        |=> (head == $past(head) + SW'(1))); // R7
    AST_SQUASH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid && live[squash_slot])
        |=> (count == {1'b0, $past(squash_slot - head)})); // R8
endmodule

// File: rtl/rsv_slot_state.sv
// Slot state: the pending-reservation mask and done flag of one ring slot.
// Applies forward, release and stop events, then clears, then loads.
// Assumes the strobes it receives are already gated by slot liveness.
module rsv_slot_state #(
    parameter int NR = rsv_pkg::DEF_NUM_REGS,
    localparam int RW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          live,
    input  logic          load,
    input  logic [NR-1:0] create,
    input  logic          clear,
    input  logic          fwd_hit,
    input  logic [RW-1:0] fwd_reg,
    input  logic          rel_hit,
    input  logic [NR-1:0] rel_mask,
    input  logic          stop_hit,
    output logic [NR-1:0] pend,
    output logic          done
);
    logic [NR-1:0] pend_nxt;
    logic          done_nxt;

    // Next pending mask and done flag, later rules overriding earlier ones.
    always_comb begin
        pend_nxt = pend;
        done_nxt = done;
        if (fwd_hit)  pend_nxt[fwd_reg] = 1'b0;
        if (rel_hit)  pend_nxt = pend_nxt & ~rel_mask;
        if (stop_hit) begin
            pend_nxt = '0;
            done_nxt = 1'b1;
        end
        if (clear) begin
            pend_nxt = '0;
            done_nxt = 1'b0;
        end
        if (load) begin
            pend_nxt = create;
            done_nxt = 1'b0;
        end
    end

    // Register the slot state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            done <= 1'b0;
        end else begin
            pend <= pend_nxt;
            done <= done_nxt;
        end
    end

    AST_ALLOC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pend == $past(create))); // R2
    AST_FWD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_hit && !load) |=> (pend[$past(fwd_reg)] == 1'b0)); // R4
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_hit && !load && !clear) |=> ((pend == '0) && done)); // R6
    AST_DEAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> ((pend == '0) && !done)); // R9
endmodule

// File: rtl/rsv_acc_net.sv
// Accumulation network: ORs the pending masks of all live slots older than the
// queried slot and tests the queried register against the result. Purely
// combinational. Assumes NT is a power of two.
module rsv_acc_net #(
    parameter int NR = rsv_pkg::DEF_NUM_REGS,
    parameter int NT = rsv_pkg::DEF_NUM_TASKS,
    localparam int SW = $clog2(NT),
    localparam int RW = $clog2(NR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT*NR-1:0] pend_flat,
    input  logic [NT-1:0]    live,
    input  logic [SW-1:0]    head,
    input  logic [SW-1:0]    qry_slot,
    input  logic [RW-1:0]    qry_reg,
    output logic             qry_ready
);
    logic [NR-1:0] acc;
    logic [SW-1:0] q_age;

    // Combine the reservations of strictly older live slots.
    always_comb begin
        q_age = qry_slot - head;
        acc   = '0;
        for (int j = 0; j < NT; j++) begin
            if (live[j] && ((SW'(j) - head) < q_age))
                acc = acc | pend_flat[j*NR +: NR];
        end
        qry_ready = !acc[qry_reg];
    end

    AST_HEAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_slot == head) |-> qry_ready); // R10
endmodule

// File: rtl/rsv_unit.sv
// Inter-task register reservation unit (top). Ties the ring controller, one
// state block per slot and the accumulation network together. Gates each
// event by the liveness of the slot it names.
// Assumes NUM_TASKS is a power of two >= 2 and NUM_REGS is a power of two.
module rsv_unit #(
    parameter int NUM_REGS  = rsv_pkg::DEF_NUM_REGS,
    parameter int NUM_TASKS = rsv_pkg::DEF_NUM_TASKS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_valid,
    input  logic [NUM_REGS-1:0]          alloc_create,
    input  logic                         commit_valid,
    input  logic                         squash_valid,
    input  logic [$clog2(NUM_TASKS)-1:0] squash_slot,
    input  logic                         fwd_valid,
    input  logic [$clog2(NUM_TASKS)-1:0] fwd_slot,
    input  logic [$clog2(NUM_REGS)-1:0]  fwd_reg,
    input  logic                         rel_valid,
    input  logic [$clog2(NUM_TASKS)-1:0] rel_slot,
    input  logic [NUM_REGS-1:0]          rel_mask,
    input  logic                         stop_valid,
    input  logic [$clog2(NUM_TASKS)-1:0] stop_slot,
    input  logic [$clog2(NUM_TASKS)-1:0] qry_slot,
    input  logic [$clog2(NUM_REGS)-1:0]  qry_reg,
    output logic                         qry_ready,
    output logic [$clog2(NUM_TASKS)-1:0] alloc_slot,
    output logic [$clog2(NUM_TASKS)-1:0] head_slot,
    output logic [NUM_TASKS-1:0]         live_mask,
    output logic [NUM_TASKS-1:0]         done_mask,
    output logic                         ring_full
);
    localparam int NR = NUM_REGS;
    localparam int NT = NUM_TASKS;
    localparam int SW = $clog2(NT);

    logic [NT-1:0]    kill_mask;
    logic [NT-1:0]    load_mask;
    logic [NT*NR-1:0] pend_flat;

    rsv_ring_ctrl #(.NT(NT)) ring_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_valid  (alloc_valid),
        .commit_valid (commit_valid),
        .squash_valid (squash_valid),
        .squash_slot  (squash_slot),
        .done_vec     (done_mask),
        .head         (head_slot),
        .tail         (alloc_slot),
        .live         (live_mask),
        .kill_mask    (kill_mask),
        .load_mask    (load_mask),
        .full         (ring_full)
    );

    for (genvar gi = 0; gi < NT; gi++) begin : g_slot
        localparam logic [SW-1:0] IDX = SW'(gi);
        logic fwd_hit, rel_hit, stop_hit;

        // Route the event ports to this slot when it is live and named.
        always_comb begin
            fwd_hit  = fwd_valid  && (fwd_slot  == IDX) && live_mask[gi];
            rel_hit  = rel_valid  && (rel_slot  == IDX) && live_mask[gi];
            stop_hit = stop_valid && (stop_slot == IDX) && live_mask[gi];
        end

        rsv_slot_state #(.NR(NR)) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .live     (live_mask[gi]),
            .load     (load_mask[gi]),
            .create   (alloc_create),
            .clear    (kill_mask[gi]),
            .fwd_hit  (fwd_hit),
            .fwd_reg  (fwd_reg),
            .rel_hit  (rel_hit),
            .rel_mask (rel_mask),
            .stop_hit (stop_hit),
            .pend     (pend_flat[gi*NR +: NR]),
            .done     (done_mask[gi])
        );
    end

    rsv_acc_net #(.NR(NR), .NT(NT)) acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_flat (pend_flat),
        .live      (live_mask),
        .head      (head_slot),
        .qry_slot  (qry_slot),
        .qry_reg   (qry_reg),
        .qry_ready (qry_ready)
    );
endmodule

// File: tb/rsv_unit_tb.sv
`timescale 1ns/1ps
module rsv_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0, commit_valid = 0, squash_valid = 0;
    logic [31:0] alloc_create = '0, rel_mask = '0;
    logic [1:0]  squash_slot = '0, fwd_slot = '0, rel_slot = '0, stop_slot = '0, qry_slot = '0;
    logic        fwd_valid = 0, rel_valid = 0, stop_valid = 0;
    logic [4:0]  fwd_reg = '0, qry_reg = '0;
    logic        qry_ready, ring_full;
    logic [1:0]  alloc_slot, head_slot;
    logic [3:0]  live_mask, done_mask;

    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rsv_unit dut_i (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_create(alloc_create),
        .commit_valid(commit_valid), .squash_valid(squash_valid), .squash_slot(squash_slot),
        .fwd_valid(fwd_valid), .fwd_slot(fwd_slot), .fwd_reg(fwd_reg),
        .rel_valid(rel_valid), .rel_slot(rel_slot), .rel_mask(rel_mask),
        .stop_valid(stop_valid), .stop_slot(stop_slot), .qry_slot(qry_slot), .qry_reg(qry_reg),
        .qry_ready(qry_ready), .alloc_slot(alloc_slot), .head_slot(head_slot),
        .live_mask(live_mask), .done_mask(done_mask), .ring_full(ring_full)
    );

    // Reference model of the ring, built from the requirements.
    logic [31:0] m_pend [4];
    bit          m_done [4];
    int          m_head = 0, m_cnt = 0;

    function automatic int m_age(int i);
        return (i - m_head + 4) % 4;
    endfunction
    function automatic bit m_live(int i);
        return m_age(i) < m_cnt;
    endfunction
    function automatic bit m_ready(int q, int r);
        for (int j = 0; j < 4; j++)
            if (m_live(j) && m_age(j) < m_age(q) && m_pend[j][r]) return 1'b0;
        return 1'b1;
    endfunction
    function automatic logic [3:0] m_livemask();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = m_live(i);
        return v;
    endfunction
    function automatic logic [3:0] m_donemask();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = m_done[i];
        return v;
    endfunction

    function automatic void model_step();
        logic [31:0] np [4];
        bit nd [4];
        int nh = m_head, nc = m_cnt;
        for (int i = 0; i < 4; i++) begin np[i] = m_pend[i]; nd[i] = m_done[i]; end
        for (int i = 0; i < 4; i++) begin
            if (!m_live(i)) continue;
            if (fwd_valid && fwd_slot == i) np[i][fwd_reg] = 1'b0;
            if (rel_valid && rel_slot == i) np[i] = np[i] & ~rel_mask;
            if (stop_valid && stop_slot == i) begin np[i] = '0; nd[i] = 1; end
        end
        if (squash_valid && m_live(squash_slot)) begin
            int k = m_age(squash_slot);
            for (int i = 0; i < 4; i++)
                if (m_live(i) && m_age(i) >= k) begin np[i] = '0; nd[i] = 0; end
            nc = k;
        end else begin
            if (commit_valid && m_cnt > 0 && m_done[m_head]) begin
                np[m_head] = '0; nd[m_head] = 0; nh = (m_head + 1) % 4; nc--;
            end
            if (alloc_valid && m_cnt < 4) begin
                int t = (m_head + m_cnt) % 4;
                np[t] = alloc_create; nd[t] = 0; nc++;
            end
        end
        for (int i = 0; i < 4; i++) begin m_pend[i] = np[i]; m_done[i] = nd[i]; end
        m_head = nh; m_cnt = nc;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_idle();
        alloc_valid = 0; commit_valid = 0; squash_valid = 0;
        fwd_valid = 0; rel_valid = 0; stop_valid = 0;
    endtask

    task automatic finish_cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        set_idle();
    endtask

    // Compare every output against the model, then advance one cycle.
    task automatic tick();
        #1;
        check("R3", {31'b0, qry_ready}, {31'b0, m_ready(qry_slot, qry_reg)});
        check("R8", {28'b0, live_mask}, {28'b0, m_livemask()});
        check("R6", {28'b0, done_mask}, {28'b0, m_donemask()});
        check("R7", {30'b0, head_slot}, m_head);
        check("R2", {30'b0, alloc_slot}, (m_head + m_cnt) % 4);
        check("R2", {31'b0, ring_full}, {31'b0, m_cnt == 4});
        finish_cycle();
    endtask

    task automatic expect_q(int s, int r, bit exp, string req);
        qry_slot = 2'(s); qry_reg = 5'(r);
        #1;
        check(req, {31'b0, qry_ready}, {31'b0, exp});
        finish_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_pend[i] = '0; m_done[i] = 0; end
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", {28'b0, live_mask}, 0);
        check("R1", {28'b0, done_mask}, 0);
        check("R1", {31'b0, ring_full}, 0);
        check("R1", {30'b0, head_slot}, 0);
        check("R1", {30'b0, alloc_slot}, 0);
        qry_slot = 2'd3; qry_reg = 5'd9;
        #0.5 check("R1", {31'b0, qry_ready}, 1);
        @(negedge clk);

        alloc_valid = 1; alloc_create = 32'h60;       tick();   // slot0: regs 5,6
        alloc_valid = 1; alloc_create = 32'h80;       tick();   // slot1: reg 7
        expect_q(1, 5, 0, "R3");
        expect_q(1, 6, 0, "R3");
        expect_q(0, 5, 1, "R10");
        expect_q(1, 7, 1, "R10");
        expect_q(2, 7, 0, "R3");
        fwd_valid = 1; fwd_slot = 0; fwd_reg = 5;      tick();
        expect_q(1, 5, 1, "R4");
        expect_q(1, 6, 0, "R4");
        alloc_valid = 1; alloc_create = 32'h600;      tick();   // slot2: regs 9,10
        rel_valid = 1; rel_slot = 2; rel_mask = 32'h200;
        alloc_valid = 1; alloc_create = 32'h0;        tick();   // slot3
        expect_q(3, 9, 1, "R5");
        expect_q(3, 10, 0, "R5");
        #1 check("R2", {31'b0, ring_full}, 1);
        alloc_valid = 1; alloc_create = 32'hFFFF_FFFF; tick();  // ignored, ring full
        #1 check("R2", {28'b0, live_mask}, 4'hF);
        check("R2", {30'b0, alloc_slot}, 0);
        expect_q(3, 9, 1, "R2");
        commit_valid = 1;                              tick();   // head not done
        #1 check("R7", {30'b0, head_slot}, 0);
        stop_valid = 1; stop_slot = 0;                 tick();
        #1 check("R6", {28'b0, done_mask}, 4'b0001);
        expect_q(1, 6, 1, "R6");
        commit_valid = 1;                              tick();
        #1 check("R7", {30'b0, head_slot}, 1);
        squash_valid = 1; squash_slot = 2; commit_valid = 1; alloc_valid = 1;
        alloc_create = 32'hFFFF_FFFF;                  tick();
        #1 check("R8", {28'b0, live_mask}, 4'b0010);
        check("R8", {30'b0, head_slot}, 1);
        alloc_valid = 1; alloc_create = 32'h0;         tick();   // slot2
        alloc_valid = 1; alloc_create = 32'h0;         tick();   // slot3
        expect_q(3, 10, 1, "R8");
        stop_valid = 1; stop_slot = 0;                 tick();   // slot0 dead
        #1 check("R9", {28'b0, done_mask}, 4'b0000);
        squash_valid = 1; squash_slot = 0;             tick();   // dead, ignored
        #1 check("R9", {28'b0, live_mask}, 4'b1110);

        // Seeded random phase against the model.
        for (int n = 0; n < 4000; n++) begin
            alloc_valid  = ($urandom % 10) < 4;
            alloc_create = $urandom & $urandom & $urandom;
            commit_valid = ($urandom % 10) < 3;
            squash_valid = ($urandom % 20) == 0;
            squash_slot  = 2'($urandom);
            fwd_valid    = ($urandom % 10) < 4;
            fwd_slot     = 2'($urandom);
            fwd_reg      = 5'($urandom);
            rel_valid    = ($urandom % 10) < 2;
            rel_slot     = 2'($urandom);
            rel_mask     = $urandom & $urandom;
            stop_valid   = ($urandom % 10) < 2;
            stop_slot    = 2'($urandom);
            qry_slot     = 2'($urandom);
            qry_reg      = 5'($urandom);
            tick();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule